// File: doc/BRIEF.md
# Call Context Address Stack

This block is the return-context store of a small controller core. Whenever a subroutine call or an interrupt entry happens, the core raises a push strobe. The block then saves the address of the instruction after the call, together with the interrupt-enable bit, the four ALU flags and the active register-bank selection, as one entry. When the core returns, it raises a pop strobe. The block offers the saved context of the top entry on its restore outputs in that same cycle, so the core can reload its program counter, flags and bank state at the edge where the entry is released. Calls and interrupts share the same twelve entries.

The block also works out where a call goes. A relative call adds the sign-extended low byte of the operand to the next-instruction address. A long call takes the full 16-bit operand as an absolute address. Pushing into a full stack and popping from an empty one are both faults. Each one raises its own sticky flag and leaves the stored entries untouched. Instruction decode and interrupt arbitration sit outside this block.

Top module: `ctx_call_stack`

## Requirements
- R1: The stack holds exactly 12 entries, and returns them in last-in, first-out order. After 12 pushes, 12 pops empty it without any fault.
- R2: A push stores `next_pc_i`, `gie_i`, `flags_i` (bit 3 = Z, bit 2 = C, bit 1 = N, bit 0 = V) and `bank_i` (2 bits) as one entry. While the stack is non-empty, the restore outputs show the top entry from the cycle after that push.
- R3: During the cycle in which `pop_i` is high, the restore outputs present the entry being popped. The depth drops at that clock edge, and the entry below becomes visible afterwards.
- R4: A push without a pop while 12 entries are held sets `overflow_o` from the next cycle on. The flag stays set until reset, and the stored entries do not change.
- R5: A pop without a push on an empty stack sets `underflow_o` from the next cycle on, and the flag stays set until reset. While the stack is empty, all restore outputs read zero.
- R6: A push and a pop in the same cycle on a non-empty stack overwrite the top entry with the current context. The depth does not change.
- R7: When `call_long_i` = 0, `target_pc_o` = `next_pc_i` + sign-extended `operand_i[7:0]`, taken modulo 2^16. This covers offsets from -128 to +127, and `operand_i[15:8]` has no effect.
- R8: When `call_long_i` = 1, `target_pc_o` = `operand_i`, regardless of `next_pc_i`.
- R9: After reset the stack is empty, both fault flags are low and the restore outputs read zero.
- R10: A push and a pop in the same cycle on an empty stack set `underflow_o` and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Save the current context (call or interrupt entry) |
| pop_i | input | 1 | Release the top entry (return) |
| call_long_i | input | 1 | 0: relative target, 1: absolute target |
| operand_i | input | 16 | Call operand: offset in bits 7:0, or an absolute address |
| next_pc_i | input | 16 | Address of the instruction after the call |
| gie_i | input | 1 | Current global interrupt enable |
| flags_i | input | 4 | Current ALU flags {Z,C,N,V} |
| bank_i | input | 2 | Current register-bank selection |
| target_pc_o | output | 16 | Computed call destination |
| rest_pc_o | output | 16 | Return address of the top entry |
| rest_gie_o | output | 1 | Saved interrupt enable of the top entry |
| rest_flags_o | output | 4 | Saved ALU flags of the top entry |
| rest_bank_o | output | 2 | Saved bank selection of the top entry |
| overflow_o | output | 1 | Sticky: a push found the stack full |
| underflow_o | output | 1 | Sticky: a pop found the stack empty |

## Verification
The call target is combinational, so the bench checks it 1 ns after driving the operand and PC, with no clock edge in between. The restore outputs follow the stored entries with no delay. A pop therefore shows its entry in the same cycle, and the bench samples it before the edge. The effect of a push, a replace or a pointer move shows up one edge later, so the bench drives at the falling edge and checks at the next falling edge. The fault flags are registered and are also checked one edge after the faulting strobe. They are checked again later to show that they stay set.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
    localparam int PC_W   = 16;
    localparam int OFS_W  = 8;
    localparam int FLAG_W = 4;
    localparam int BANK_W = 2;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              gie;
        logic [FLAG_W-1:0] flags;
        logic [BANK_W-1:0] bank;
    } ctx_t;
endpackage

// File: rtl/ctx_target_calc.sv
module ctx_target_calc
    import ctx_stack_pkg::*;
(
    input  logic            long_i,
    input  logic [PC_W-1:0] operand_i,
    input  logic [PC_W-1:0] next_pc_i,
    output logic [PC_W-1:0] target_o
);
    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] rel_sum;

    always_comb begin
        ofs_ext = {{(PC_W-OFS_W){operand_i[OFS_W-1]}}, operand_i[OFS_W-1:0]};
        rel_sum = next_pc_i + ofs_ext;
        target_o = long_i ? operand_i : rel_sum;
    end
endmodule

// File: rtl/ctx_stack_store.sv
module ctx_stack_store
    import ctx_stack_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  ctx_t wr_ctx_i,
    output ctx_t top_ctx_o,
    output logic overflow_o,
    output logic underflow_o
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ovf;
        logic             unf;
    } st_t;

    st_t              st_d, st_q;
    logic             wr_en_d;
    logic [IDX_W-1:0] wr_idx_d;
    logic             empty, full;
    ctx_t             mem_q [DEPTH];

    always_comb begin
        empty    = (st_q.ptr == '0);
        full     = (st_q.ptr == PTR_W'(DEPTH));
        st_d     = st_q;
        wr_en_d  = 1'b0;
        wr_idx_d = IDX_W'(st_q.ptr);
        unique case ({push_i, pop_i})
            2'b10: begin
                if (full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    wr_en_d  = 1'b1;
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
            2'b01: begin
                if (empty) st_d.unf = 1'b1;
                else       st_d.ptr = st_q.ptr - 1'b1;
            end
            2'b11: begin
                if (empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    wr_en_d  = 1'b1;
                    wr_idx_d = IDX_W'(st_q.ptr - 1'b1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en_d && (wr_idx_d == IDX_W'(g)))
                mem_q[g] <= wr_ctx_i;
        end
    end

    always_comb begin
        top_ctx_o = '0;
        if (!empty) top_ctx_o = mem_q[IDX_W'(st_q.ptr - 1'b1)];
    end

    assign overflow_o  = st_q.ovf;
    assign underflow_o = st_q.unf;

    // R1: depth never exceeds the capacity
    assert_ptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= PTR_W'(DEPTH));
    // R2: a push into a non-full stack grows it by one
    assert_push_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full) |=> (st_q.ptr == $past(st_q.ptr) + 1'b1));
    // R4: push on full raises overflow and keeps the depth
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full) |=> (overflow_o && $stable(st_q.ptr)));
    // R4: overflow is sticky
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    // R5: pop on empty raises underflow
    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty) |=> (underflow_o && st_q.ptr == '0));
    // R5: underflow is sticky
    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);
    // R6: replace keeps the depth
    assert_replace_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty) |=> $stable(st_q.ptr));
    // R5: empty stack restores zero
    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (top_ctx_o == '0));
endmodule

// File: rtl/ctx_call_stack.sv
module ctx_call_stack
    import ctx_stack_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic        call_long_i,
    input  logic [15:0] operand_i,
    input  logic [15:0] next_pc_i,
    input  logic        gie_i,
    input  logic [3:0]  flags_i,
    input  logic [1:0]  bank_i,
    output logic [15:0] target_pc_o,
    output logic [15:0] rest_pc_o,
    output logic        rest_gie_o,
    output logic [3:0]  rest_flags_o,
    output logic [1:0]  rest_bank_o,
    output logic        overflow_o,
    output logic        underflow_o
);
    ctx_t cur_ctx;
    ctx_t top_ctx;

    always_comb begin
        cur_ctx.pc    = next_pc_i;
        cur_ctx.gie   = gie_i;
        cur_ctx.flags = flags_i;
        cur_ctx.bank  = bank_i;
    end

    ctx_target_calc u_target (
        .long_i    (call_long_i),
        .operand_i (operand_i),
        .next_pc_i (next_pc_i),
        .target_o  (target_pc_o)
    );

    ctx_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .wr_ctx_i    (cur_ctx),
        .top_ctx_o   (top_ctx),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    assign rest_pc_o    = top_ctx.pc;
    assign rest_gie_o   = top_ctx.gie;
    assign rest_flags_o = top_ctx.flags;
    assign rest_bank_o  = top_ctx.bank;

    // R8: a long call ignores the next-instruction address
    assert_long_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_long_i |-> (target_pc_o == operand_i));
endmodule

// File: tb/sim_ctx_call_stack.sv
module sim_ctx_call_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, call_long_i = 1'b0;
    logic [15:0] operand_i = '0, next_pc_i = '0;
    logic        gie_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [1:0]  bank_i = '0;
    logic [15:0] target_pc_o, rest_pc_o;
    logic        rest_gie_o;
    logic [3:0]  rest_flags_o;
    logic [1:0]  rest_bank_o;
    logic        overflow_o, underflow_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ctx_call_stack u0 (.*);

    // {long, operand, next_pc, expected target}
    localparam logic [48:0] VEC [8] = '{
        {1'b0, 16'h0005, 16'h1000, 16'h1005},
        {1'b0, 16'h00FF, 16'h1000, 16'h0FFF},
        {1'b0, 16'h007F, 16'h2000, 16'h207F},
        {1'b0, 16'h0080, 16'h2000, 16'h1F80},
        {1'b0, 16'hAB10, 16'h0100, 16'h0110},
        {1'b0, 16'h0002, 16'hFFFF, 16'h0001},
        {1'b1, 16'hBEEF, 16'h1234, 16'hBEEF},
        {1'b1, 16'h0000, 16'hFFFF, 16'h0000}
    };

    function automatic logic [22:0] ctx_of(int i);
        logic [15:0] pc = 16'h1000 + 16'(i) * 16'h0123;
        logic [3:0]  fl = 4'(i) ^ 4'b1010;
        return {pc, 1'(i), fl, 2'(i)};
    endfunction

    function automatic logic [22:0] top_now();
        return {rest_pc_o, rest_gie_o, rest_flags_o, rest_bank_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [22:0] c);
        {next_pc_i, gie_i, flags_i, bank_i} = c;
    endtask

    task automatic step(input logic p, input logic q, input logic [22:0] c);
        set_ctx(c);
        push_i = p;
        pop_i  = q;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 overflow", 32'(overflow_o), 0);
        chk("R9 underflow", 32'(underflow_o), 0);
        chk("R9 restore", 32'(top_now()), 0);

        // R7/R8: target vectors
        foreach (VEC[k]) begin
            {call_long_i, operand_i, next_pc_i} = VEC[k][48:16];
            #1;
            chk(VEC[k][48] ? "R8 long target" : "R7 relative target",
                32'(target_pc_o), 32'(VEC[k][15:0]));
        end
        call_long_i = 1'b0;

        // R1/R2: fill all 12 entries
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b0, ctx_of(i));
            chk("R2 pushed context on top", 32'(top_now()), 32'(ctx_of(i)));
        end
        chk("R4 no overflow at 12", 32'(overflow_o), 0);
        // R4: 13th push lost
        step(1'b1, 1'b0, ctx_of(40));
        chk("R4 overflow set", 32'(overflow_o), 1);
        chk("R4 top unchanged", 32'(top_now()), 32'(ctx_of(11)));

        // R1/R3: LIFO pops, entry visible in the pop cycle
        for (int k = 11; k >= 0; k--) begin
            pop_i = 1'b1;
            #1;
            chk("R3 pop cycle restore", 32'(top_now()), 32'(ctx_of(k)));
            @(posedge clk);
            @(negedge clk);
            pop_i = 1'b0;
        end
        chk("R1 twelve pops no underflow", 32'(underflow_o), 0);
        chk("R5 empty restore zero", 32'(top_now()), 0);
        // R5: pop empty
        step(1'b0, 1'b1, '0);
        chk("R5 underflow set", 32'(underflow_o), 1);
        chk("R5 restore still zero", 32'(top_now()), 0);
        step(1'b0, 1'b0, '0);
        chk("R4 overflow sticky", 32'(overflow_o), 1);
        chk("R5 underflow sticky", 32'(underflow_o), 1);

        // R6: replace top
        do_reset();
        step(1'b1, 1'b0, ctx_of(0));
        step(1'b1, 1'b0, ctx_of(1));
        step(1'b1, 1'b1, ctx_of(5));
        chk("R6 replaced top", 32'(top_now()), 32'(ctx_of(5)));
        step(1'b0, 1'b1, '0);
        chk("R6 depth kept, entry below", 32'(top_now()), 32'(ctx_of(0)));
        step(1'b0, 1'b1, '0);
        chk("R6 empty after two pops", 32'(top_now()), 0);
        chk("R6 no underflow", 32'(underflow_o), 0);

        // R10: push+pop on empty
        do_reset();
        step(1'b1, 1'b1, ctx_of(7));
        chk("R10 underflow set", 32'(underflow_o), 1);
        chk("R10 nothing stored", 32'(top_now()), 0);
        step(1'b1, 1'b0, ctx_of(2));
        step(1'b0, 1'b1, '0);
        chk("R10 single entry only", 32'(top_now()), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule